// File: doc/BRIEF.md
# Reloadable Timer and Event Counter

This block is a 16-bit up-counter with a reload value. A control register selects the count source. The counter can step on a prescaled system-clock enable (timer). It can step on one chosen edge of an external pin (event counter). It can also step on the clock enable only while the pin sits at a chosen level (pulse-width measurement). When the counter wraps past its all-ones value, it takes the reload value and raises an interrupt request for one cycle.

Software reaches the block over a byte-wide register bus. Writes to the reload value are split into two bytes. The low byte waits in a buffer until the high byte arrives, and then both bytes land together. A read of the low count byte freezes the high byte in a shadow register, so the two byte reads always describe the same instant. A read of either count byte holds off counting for that cycle, so one count can be lost.

In pulse-width mode the block stops by itself at the end of the pulse and keeps the measured width in the counter. Software can then read it at leisure.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset the count, the reload value, the control register and `irq` are all zero.
- R2: The control register sits at address 2. Bits [1:0] hold the mode (00 idle, 01 event counter, 10 timer, 11 pulse width), bit 2 is run-enable and bit 3 is edge-select. Bits [7:4] read as zero.
- R3: A write to address 0 fills only the low-byte buffer and changes neither the count nor the reload value. A write to address 1 stores {written byte, buffer} as the reload value. If run-enable is 0 at that moment, the same value is also copied into the count.
- R4: In timer mode with run-enable set, the count rises by one in each cycle where `tickEn` is high. With run-enable clear, the count does not move.
- R5: In event mode with run-enable set, the count rises by one for each edge of `extIn` after the synchronizer. The counted edge is rising when edge-select is 0 and falling when it is 1. `tickEn` has no effect in this mode.
- R6: In pulse-width mode with run-enable set, the count rises on each `tickEn` cycle while `extIn` is at its active level (high when edge-select is 0, low when it is 1). When the pin leaves the active level, run-enable clears and the count is kept.
- R7: An increment that occurs at count 0xFFFF loads the reload value into the count. In the cycle that follows, `irq` is high for exactly one cycle.
- R8: Reading address 0 returns count bits [7:0] and copies count bits [15:8] into a shadow register. Reading address 1 returns that shadow, even if the count has moved since then.
- R9: An increment that falls in a cycle where address 0 or 1 is being read is dropped.
- R10: If a write to address 1 coincides with a wrap, the count reloads with the value just written.
- R11: In idle mode (00) the count never changes through counting, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Prescaled system-clock enable (one cycle per tick) |
| extIn | input | 1 | External count / gate pin (asynchronous) |
| busAddr | input | 2 | Register address: 0 count/reload low, 1 count/reload high, 2 control |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational from busAddr) |
| irq | output | 1 | One-cycle interrupt request on wrap |

## Verification
Two functions can fall in the same cycle. The first is a wrap-and-reload. The second is either a high-byte commit of the reload value or a byte read of the count. The bench provokes both pairs by driving `tickEn` together with the bus strobe in the cycle where the count stands at 0xFFFF or at a known value. For the commit case, it expects the count to take the freshly written value and `irq` to pulse. For the read case, it expects the tick to be lost, so the final count is one lower than the number of ticks driven.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmr_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic incr;     // step the counter this cycle
    logic wrLow;    // fill the low-byte buffer
    logic wrHigh;   // commit {high, buffer} to reload value
    logic loadCnt;  // also copy the committed value into the count
    logic capHi;    // freeze count high byte into shadow
  } dp_strobe_t;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTRL_W = 4;

endpackage

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
  import tmr_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              extIn,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              atMax,
  output dp_strobe_t        strobe,
  output tmr_mode_e         modeSel,
  output logic              runEn,
  output logic              edgeSel,
  output logic              irq
);

  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic extLvl;
  logic extPrev;
  logic riseEv;
  logic fallEv;
  logic activeEdge;
  logic activeLvl;
  logic trailing;
  logic readStall;
  logic srcPulse;
  logic ctrlWrite;

  // Pin synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extIn};
      end
    end
  endgenerate

  assign extLvl = syncQ[SYNC_TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extPrev <= 1'b0;
    else       extPrev <= extLvl;
  end

  assign riseEv     = extLvl & ~extPrev;
  assign fallEv     = ~extLvl & extPrev;
  assign activeEdge = edgeSel ? fallEv : riseEv;
  assign activeLvl  = extLvl ^ edgeSel;
  assign trailing   = edgeSel ? riseEv : fallEv;

  assign readStall = busRd && ((busAddr == ADDR_LO) || (busAddr == ADDR_HI));
  assign ctrlWrite = busWr && (busAddr == ADDR_CTRL);

  always_comb begin
    unique case (modeSel)
      MODE_EVENT: srcPulse = activeEdge;
      MODE_TIMER: srcPulse = tickEn;
      MODE_PULSE: srcPulse = tickEn & activeLvl;
      default:    srcPulse = 1'b0;
    endcase
  end

  // Control register; bus write wins over the pulse-end stop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeSel <= MODE_IDLE;
      runEn   <= 1'b0;
      edgeSel <= 1'b0;
    end else if (ctrlWrite) begin
      modeSel <= tmr_mode_e'(ctrlWdata[1:0]);
      runEn   <= ctrlWdata[2];
      edgeSel <= ctrlWdata[3];
    end else if (modeSel == MODE_PULSE && runEn && trailing) begin
      runEn <= 1'b0;
    end
  end

  always_comb begin
    strobe.incr    = runEn & srcPulse & ~readStall;
    strobe.wrLow   = busWr && (busAddr == ADDR_LO);
    strobe.wrHigh  = busWr && (busAddr == ADDR_HI);
    strobe.loadCnt = busWr && (busAddr == ADDR_HI) && !runEn;
    strobe.capHi   = busRd && (busAddr == ADDR_LO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= strobe.incr & atMax;
  end

endmodule

// File: rtl/tmr_evt_dp.sv
module tmr_evt_dp
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dp_strobe_t             strobe,
  input  logic [BUS_W-1:0]       busWdata,
  output logic [CNT_W-1:0]       countVal,
  output logic [CNT_W-1:0]       preloadVal,
  output logic [CNT_W-BUS_W-1:0] shadowHi,
  output logic                   atMax
);

  localparam int HI_W = CNT_W - BUS_W;

  logic [BUS_W-1:0] lowBuf;
  logic [CNT_W-1:0] commitVal;

  assign commitVal = {busWdata[HI_W-1:0], lowBuf};
  assign atMax     = &countVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lowBuf <= '0;
    else if (strobe.wrLow) lowBuf <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preloadVal <= '0;
    else if (strobe.wrHigh) preloadVal <= commitVal;
  end

  // Counter: direct load when stopped, else step / reload
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobe.loadCnt) begin
      countVal <= commitVal;
    end else if (strobe.incr) begin
      if (atMax) countVal <= strobe.wrHigh ? commitVal : preloadVal;
      else       countVal <= countVal + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowHi <= '0;
    else if (strobe.capHi) shadowHi <= countVal[CNT_W-1:BUS_W];
  end

endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
  import tmr_evt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             extIn,
  input  logic [1:0]       busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  logic [BUS_W-1:0] busWdata,
  output logic [BUS_W-1:0] busRdata,
  output logic             irq
);

  localparam int HI_W = CNT_W - BUS_W;

  dp_strobe_t       strobe;
  tmr_mode_e        modeSel;
  logic             runEn;
  logic             edgeSel;
  logic             atMax;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] preloadVal;
  logic [HI_W-1:0]  shadowHi;

  tmr_evt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .extIn     (extIn),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .ctrlWdata (busWdata[CTRL_W-1:0]),
    .atMax     (atMax),
    .strobe    (strobe),
    .modeSel   (modeSel),
    .runEn     (runEn),
    .edgeSel   (edgeSel),
    .irq       (irq)
  );

  tmr_evt_dp #(.CNT_W(CNT_W), .BUS_W(BUS_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .countVal   (countVal),
    .preloadVal (preloadVal),
    .shadowHi   (shadowHi),
    .atMax      (atMax)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_LO:   busRdata = countVal[BUS_W-1:0];
      ADDR_HI:   busRdata = BUS_W'(shadowHi);
      ADDR_CTRL: busRdata = {{(BUS_W-CTRL_W){1'b0}}, edgeSel, runEn, modeSel};
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_evt_chk.sv
module tmr_evt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             irq,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] preloadVal,
  input logic [1:0]       modeSel,
  input logic             runEn,
  input logic             busWr,
  input logic             busRd,
  input logic [1:0]       busAddr
);

  // R7: after a wrap the count holds the reload value
  a_r7_reload_on_irq: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> countVal == preloadVal);

  // R7: a wrap only happens while running
  a_r7_irq_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(runEn));

  // R9: count byte reads freeze the counter
  a_r9_read_stall: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busAddr[1] && !busWr) |=> $stable(countVal));

  // R11: idle mode never counts
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && !busWr) |=> $stable(countVal));

  // R4: without bus writes the count only steps by one or reloads
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> (countVal == $past(countVal) ||
                countVal == $past(countVal) + 1'b1 || irq));

endmodule

bind tmr_evt_unit tmr_evt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .irq        (irq),
  .countVal   (countVal),
  .preloadVal (preloadVal),
  .modeSel    (modeSel),
  .runEn      (runEn),
  .busWr      (busWr),
  .busRd      (busRd),
  .busAddr    (busAddr)
);

// File: tb/tmr_evt_unit_tb_top.sv
module tmr_evt_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       extIn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       irq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  tmr_evt_unit dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn(extIn),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    busRead(2'd0, lo);
    busRead(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic setCtrl(input logic [1:0] m, input logic run, input logic es);
    busWrite(2'd2, {4'b0, es, run, m});
  endtask

  task automatic setCount(input logic [15:0] v);
    setCtrl(2'b10, 1'b0, 1'b0);
    busWrite(2'd0, v[7:0]);
    busWrite(2'd1, v[15:8]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic setExt(input logic v);
    @(negedge clk);
    extIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [7:0] c;
    logic [15:0] v;
    check("R1 irq", {15'd0, irq}, 16'd0);
    busRead(2'd2, c);
    check("R1 ctrl", {8'd0, c}, 16'h0000);
    read16(v);
    check("R1 count", v, 16'h0000);
  endtask

  task automatic test_ctrl();
    logic [7:0] c;
    busWrite(2'd2, 8'hFB);
    busRead(2'd2, c);
    check("R2 ctrl readback", {8'd0, c}, 16'h000B);
    setCtrl(2'b00, 1'b0, 1'b0);
  endtask

  task automatic test_preload();
    logic [15:0] v;
    busWrite(2'd0, 8'h34);
    read16(v);
    check("R3 low write buffers only", v, 16'h0000);
    busWrite(2'd1, 8'h12);
    read16(v);
    check("R3 commit loads stopped count", v, 16'h1234);
  endtask

  task automatic test_timer();
    logic [15:0] v;
    setCtrl(2'b10, 1'b1, 1'b0);
    ticks(5);
    setCtrl(2'b10, 1'b0, 1'b0);
    read16(v);
    check("R4 timer counts ticks", v, 16'h1239);
    ticks(3);
    read16(v);
    check("R4 stopped holds", v, 16'h1239);
  endtask

  task automatic test_idle();
    logic [15:0] v;
    setCount(16'h0077);
    setCtrl(2'b00, 1'b1, 1'b0);
    ticks(4);
    setExt(1'b1);
    setExt(1'b0);
    read16(v);
    check("R11 idle no count", v, 16'h0077);
  endtask

  task automatic test_event();
    logic [15:0] v;
    setCount(16'h0000);
    setCtrl(2'b01, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      setExt(1'b1);
      setExt(1'b0);
    end
    ticks(5);
    setCtrl(2'b01, 1'b0, 1'b0);
    read16(v);
    check("R5 rising edges, tickEn ignored", v, 16'h0003);
    setCount(16'h0000);
    setCtrl(2'b01, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) begin
      setExt(1'b1);
      setExt(1'b0);
    end
    setCtrl(2'b01, 1'b0, 1'b1);
    read16(v);
    check("R5 falling edges", v, 16'h0002);
  endtask

  task automatic test_pulse();
    logic [15:0] v;
    logic [7:0] c;
    setCount(16'h0000);
    setCtrl(2'b11, 1'b1, 1'b0);
    ticks(3);
    setExt(1'b1);
    ticks(6);
    setExt(1'b0);
    busRead(2'd2, c);
    check("R6 run cleared at trailing edge", {8'd0, c}, 16'h0003);
    ticks(3);
    read16(v);
    check("R6 width kept", v, 16'h0006);
  endtask

  task automatic test_overflow();
    logic [15:0] v;
    setCount(16'hFFFE);
    setCtrl(2'b10, 1'b1, 1'b0);
    busWrite(2'd0, 8'h00);
    busWrite(2'd1, 8'h10);
    ticks(1);
    check("R7 no irq before wrap", {15'd0, irq}, 16'd0);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    check("R7 irq after wrap", {15'd0, irq}, 16'd1);
    @(negedge clk);
    check("R7 irq one cycle", {15'd0, irq}, 16'd0);
    setCtrl(2'b10, 1'b0, 1'b0);
    read16(v);
    check("R7 reload value (R3 running commit)", v, 16'h1000);
  endtask

  task automatic test_shadow();
    logic [7:0] b;
    setCount(16'h12FF);
    setCtrl(2'b10, 1'b1, 1'b0);
    busRead(2'd0, b);
    check("R8 low byte", {8'd0, b}, 16'h00FF);
    ticks(1);
    busRead(2'd1, b);
    check("R8 shadow high", {8'd0, b}, 16'h0012);
    busRead(2'd0, b);
    check("R8 new low", {8'd0, b}, 16'h0000);
    busRead(2'd1, b);
    check("R8 new high", {8'd0, b}, 16'h0013);
    setCtrl(2'b10, 1'b0, 1'b0);
  endtask

  task automatic test_stall();
    logic [15:0] v;
    setCount(16'h0050);
    setCtrl(2'b10, 1'b1, 1'b0);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 2'd0; busRd = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busRd = 1'b0;
    ticks(2);
    setCtrl(2'b10, 1'b0, 1'b0);
    read16(v);
    check("R9 tick during read dropped", v, 16'h0052);
  endtask

  task automatic test_collide();
    logic [15:0] v;
    setCount(16'hFFFF);
    busWrite(2'd0, 8'hCD);
    setCtrl(2'b10, 1'b1, 1'b0);
    @(negedge clk);
    tickEn = 1'b1; busAddr = 2'd1; busWdata = 8'hAB; busWr = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWr = 1'b0;
    check("R10 irq on coinciding wrap", {15'd0, irq}, 16'd1);
    setCtrl(2'b10, 1'b0, 1'b0);
    read16(v);
    check("R10 reload uses new value", v, 16'hABCD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_ctrl();
    test_preload();
    test_timer();
    test_idle();
    test_event();
    test_pulse();
    test_overflow();
    test_shadow();
    test_stall();
    test_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule